// File: doc/BRIEF.md
# Iterative Serial Right Shifter

This block shifts a data word right, one bit position per clock, and fills the vacated high bits with zeros. A request supplies a 5-bit immediate shift amount, a count-register word and the operand word. A nonzero immediate sets the shift amount. A zero immediate makes the block take the amount from the low five bits of the count-register word. The block captures all operands on the accepting edge. It then steps through a short setup sequence and runs a down-counter, shifting once per cycle until the counter is empty.

The block has no buffering and no back-pressure. A request is a single-cycle `start`. The block accepts it only while idle and ignores it at any other time. On completion, `done` pulses for one cycle. `result` holds the finished word until the next completion overwrites it. A caller that needs the result must sample it on the `done` cycle or at any time before the next request finishes.

Top module: `serial_rshift_unit`

## Requirements
- R1: After reset, `result` is all zeros and `done` is low.
- R2: When `imm_cnt` is nonzero at the accepting edge, the delivered `result` equals `operand` shifted right logically by `imm_cnt`.
- R3: When `imm_cnt` is zero, the shift amount is bits 4..0 of `cnt_reg`, and bits 31..5 of `cnt_reg` have no effect on the result.
- R4: The shift is logical: each step moves every bit one place toward bit 0 and loads a zero into bit 31.
- R5: When `imm_cnt` and `cnt_reg[4:0]` are both zero, the block returns `operand` unchanged and performs no shift steps.
- R6: For a shift amount k, `done` first goes high exactly k+3 rising edges after the edge that samples `start`.
- R7: `done` stays high for exactly one cycle per accepted request.
- R8: A `start` that arrives while a request is in flight is ignored. It does not change the in-flight result and produces no extra `done`.
- R9: `result` changes only on the cycle in which `done` rises, and it is held stable between completions.
- R10: Operands are captured at the accepting edge. Changes to `imm_cnt`, `cnt_reg` or `operand` after that edge do not affect the in-flight result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only while idle |
| imm_cnt | input | 5 | Immediate shift amount; zero selects `cnt_reg` |
| cnt_reg | input | 32 | Count-register word; low five bits used as a fallback amount |
| operand | input | 32 | Word to be shifted |
| result | output | 32 | Last finished word, held until the next completion |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume `start` is a clean synchronous level that is meaningful only at rising edges. They also assume the internal count never exceeds 31, which holds because both count sources are five bits wide. The stimulus drives every input half a cycle away from the sampling edge. It holds `start` for exactly one edge per request and deliberately scrambles the operand inputs once a request has been accepted. Busy-time `start` pulses are injected only while a request is in flight, so every `done` can be traced to a single accepted request.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEL   = 2'd1,
    ST_COPY  = 2'd2,
    ST_SHIFT = 2'd3
  } srs_state_e;
endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cnt_zero,
  output srs_state_e state_q,
  output logic       accept,
  output logic       done_q
);
  srs_state_e state_d;

  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_SEL;
      ST_SEL:   state_d = ST_COPY;
      ST_COPY:  state_d = ST_SHIFT;
      ST_SHIFT: if (cnt_zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_SHIFT) && cnt_zero;
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_SEL));
endmodule

// File: rtl/srs_count.sv
module srs_count
  import srs_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  srs_state_e       state_q,
  input  logic             accept,
  input  logic [CNT_W-1:0] imm_cnt,
  input  logic [CNT_W-1:0] alt_cnt,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] alt_q;

  assign cnt_zero = (n_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q   <= '0;
      alt_q <= '0;
    end else begin
      if (accept) begin
        n_q   <= imm_cnt;
        alt_q <= alt_cnt;
      end else if (state_q == ST_SEL) begin
        if (cnt_zero) n_q <= alt_q;
      end else if (state_q == ST_SHIFT && !cnt_zero) begin
        n_q <= n_q - CNT_W'(1);
      end
    end
  end

  // R3
  fallback_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEL && cnt_zero) |=> (n_q == $past(alt_q)));

  // R6
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && !cnt_zero) |=> (n_q == $past(n_q) - CNT_W'(1)));
endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  srs_state_e        state_q,
  input  logic              accept,
  input  logic              cnt_zero,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result_q
);
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] work_q;
  logic [DATA_W-1:0] step_v;
  logic              shift_en;

  assign shift_en = (state_q == ST_SHIFT) && !cnt_zero;

  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    if (i == DATA_W - 1) begin : g_top
      assign step_v[i] = 1'b0;
    end else begin : g_mid
      assign step_v[i] = work_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opnd_q   <= '0;
      work_q   <= '0;
      result_q <= '0;
    end else begin
      if (accept) opnd_q <= operand;
      if (state_q == ST_COPY) work_q <= opnd_q;
      else if (shift_en)      work_q <= step_v;
      if (state_q == ST_SHIFT && cnt_zero) result_q <= work_q;
    end
  end

  // R4
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (work_q == {1'b0, $past(work_q[DATA_W-1:1])}));
endmodule

// File: rtl/serial_rshift_unit.sv
module serial_rshift_unit
  import srs_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  imm_cnt,
  input  logic [DATA_W-1:0] cnt_reg,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  srs_state_e state_q;
  logic       accept;
  logic       cnt_zero;
  logic       unused_cnt_hi;

  assign unused_cnt_hi = ^cnt_reg[DATA_W-1:CNT_W];

  srs_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cnt_zero (cnt_zero),
    .state_q  (state_q),
    .accept   (accept),
    .done_q   (done)
  );

  srs_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .accept   (accept),
    .imm_cnt  (imm_cnt),
    .alt_cnt  (cnt_reg[CNT_W-1:0]),
    .cnt_zero (cnt_zero)
  );

  srs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .accept   (accept),
    .cnt_zero (cnt_zero),
    .operand  (operand),
    .result_q (result)
  );

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

// File: tb/tb_serial_rshift_unit.sv
module tb_serial_rshift_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  imm_cnt = '0;
  logic [31:0] cnt_reg = '0;
  logic [31:0] operand = '0;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;

  serial_rshift_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .imm_cnt(imm_cnt),
    .cnt_reg(cnt_reg), .operand(operand), .result(result), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int eff_count(logic [4:0] imm, logic [31:0] creg);
    return (imm != 0) ? int'(imm) : int'(creg[4:0]);
  endfunction

  function automatic logic [31:0] exp_shift(logic [4:0] imm, logic [31:0] creg,
                                            logic [31:0] op);
    return op >> eff_count(imm, creg);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [4:0] imm, logic [31:0] creg, logic [31:0] op,
                        bit inject, string req);
    int cyc = 0;
    int k;
    logic [31:0] expv;
    k = eff_count(imm, creg);
    expv = exp_shift(imm, creg, op);
    @(negedge clk);
    start = 1'b1; imm_cnt = imm; cnt_reg = creg; operand = op;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R10: scramble inputs after capture
    imm_cnt = 5'($urandom); cnt_reg = $urandom; operand = $urandom;
    forever begin
      if (inject && cyc == 1) start = 1'b1;
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = 1'b0;
      if (done) break;
      if (cyc > 40) break;
    end
    // R6
    check(cyc == k + 3, {req, " R6 latency"}, 32'(cyc), 32'(k + 3));
    check(result == expv, req, result, expv);
    @(posedge clk);
    @(negedge clk);
    // R7
    check(done == 1'b0, {req, " R7 single pulse"}, 32'(done), 32'd0);
    // R9 / R8: held, no extra done
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(result == expv && done == 1'b0, {req, " R9/R8 hold"}, result, expv);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(result == 32'h0 && done == 1'b0, "R1 reset state", result, 32'h0);
    rst_n = 1'b1;

    // R2 directed
    run_op(5'd1,  32'h0,        32'h8000_0001, 1'b0, "R2 imm=1");
    run_op(5'd31, 32'h0,        32'hFFFF_FFFF, 1'b0, "R2 imm=31");
    // R3 fallback, upper bits of cnt_reg ignored
    run_op(5'd0,  32'hFFFF_FFE4, 32'hDEAD_BEEF, 1'b0, "R3 fallback=4");
    run_op(5'd0,  32'h0000_001F, 32'h8000_0000, 1'b0, "R3 fallback=31");
    // R4 zero fill on all-ones
    run_op(5'd16, 32'h0,        32'hFFFF_FFFF, 1'b0, "R4 zero fill");
    // R5 both counts zero
    run_op(5'd0,  32'hFFFF_FFE0, 32'h1234_5678, 1'b0, "R5 no shift");
    // R8 busy start
    run_op(5'd7,  32'h0,        32'hA5A5_A5A5, 1'b1, "R8 busy start");
    run_op(5'd0,  32'h0,        32'h0F0F_0F0F, 1'b1, "R8 busy start k=0");

    for (int i = 0; i < 200; i++) begin
      logic [4:0]  ri;
      logic [31:0] rc;
      logic [31:0] ro;
      ri = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
      rc = $urandom;
      ro = $urandom;
      run_op(ri, rc, ro, 1'($urandom), "R2/R3/R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule